// File: doc/BRIEF.md
# SDRAM Bank State and Timing Tracker

This block follows the decoded command stream of a four-bank SDRAM, one command per clock. It can sit beside a memory controller or act as a passive monitor on the bus. For every bank it tracks whether a row is open, which row that is, and the cycle timers that govern the next legal command. From that state it drives a per-bank ready indication. When a command breaks a state rule or a timing rule, it reports a violation code.

Every timing limit is a parameter counted in whole clocks, so a limit given in nanoseconds is rounded up before it is set. Address bit 10 has two jobs. On a PRECHARGE it selects whether all banks close. On a READ or WRITE it requests auto precharge. The burst length input tells the tracker when an auto-precharged burst ends. A command that is flagged is reported and otherwise ignored, so the tracked state always reflects only the legal command history.

Top module: `sdram_bank_tracker`

## Requirements
- R1: After synchronous reset all banks are idle, every bank_ready_o bit is 1, and viol_o, viol_code_o and viol_sticky_o are 0.
- R2: Command codes are NOP=0, ACTIVE=1, READ=2, WRITE=3, PRECHARGE=4, AUTO REFRESH=5, LOAD MODE=6, BURST TERMINATE=7. An ACTIVE to an idle bank opens it with the row on addr_i from the next cycle on. An ACTIVE to an open bank is flagged with code 1.
- R3: A READ or WRITE to an idle bank is flagged with code 2. A READ or WRITE to an open bank is flagged with code 4 until T_RCD cycles after its ACTIVE, and is legal from that cycle on.
- R4: An ACTIVE issued fewer than T_RC cycles after the previous ACTIVE to the same bank, or after an AUTO REFRESH, is flagged with code 5.
- R5: A PRECHARGE with a10_i=0 closes only the bank on bank_i. An ACTIVE to that bank is flagged with code 6 until T_RP cycles after the precharge.
- R6: A PRECHARGE with a10_i=1 closes every bank, whatever the value of bank_i.
- R7: A READ or WRITE with a10_i=1 and bl_code_i of 0, 1, 2 or 3 (1, 2, 4 or 8 beats) keeps the bank open up to and including the cycle of beat BL-1, counting the command cycle as beat 0. The bank is closed after that cycle, and T_RP counts from it. With bl_code_i 4 to 7 (full page), a10_i is ignored and the row stays open.
- R8: AUTO REFRESH or LOAD MODE is flagged with code 3 while any bank is open, and with code 6 while any bank is still inside T_RP.
- R9: Any command other than NOP issued fewer than T_MRD cycles after a legal LOAD MODE is flagged with code 7. This check takes priority over all other checks.
- R10: BURST TERMINATE is never flagged except under R9. It leaves rows open and cancels any pending auto precharge of the bank last read or written.
- R11: A violation shows on viol_o and viol_code_o in the cycle after the command, for that one cycle only. Code bit 2 is set for timing errors (4 to 7) and clear for state errors (1 to 3). viol_sticky_o stays set until reset.
- R12: A flagged command changes neither the open state nor the row of any bank.
- R13: bank_ready_o[b] is 1 when no LOAD MODE wait is running and either bank b is open with T_RCD elapsed, or bank b is idle with T_RC and T_RP both elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Registered command code (see R2) |
| bank_i | input | BANK_W | Bank select |
| a10_i | input | 1 | Address bit 10: precharge-all or auto precharge |
| addr_i | input | ROW_W | Row address, used with ACTIVE |
| bl_code_i | input | 3 | Burst length code for auto precharge timing |
| bank_open_o | output | NBANK | One bit per bank, set while a row is open |
| bank_ready_o | output | NBANK | Per-bank ready-to-issue indication |
| open_row_o | output | NBANK*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |
| viol_o | output | 1 | Violation pulse, one cycle |
| viol_code_o | output | 3 | Violation code, valid with viol_o |
| viol_sticky_o | output | 1 | Set by any violation, cleared only by reset |

## Verification
Every result of the block appears one register stage after the command that causes it. The open state, the row, the timers that feed bank_ready_o and the violation code all update at the same clock edge that takes the command. The bench drives each command at a falling edge and compares the outputs at the next falling edge. At that point exactly one rising edge has consumed the command. Timing windows are probed by placing commands one cycle inside and exactly at each limit, counted from the cycle that took the starting command. For auto precharge, the closing edge is beat BL-1 after the READ or WRITE.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_REF  = 3'd5,
        CMD_LMR  = 3'd6,
        CMD_BST  = 3'd7
    } cmd_e;

    // Bit 2 set marks a timing error, clear marks a state error.
    typedef enum logic [2:0] {
        VIO_NONE         = 3'd0,
        VIO_BANK_OPEN    = 3'd1,
        VIO_BANK_CLOSED  = 3'd2,
        VIO_NOT_ALL_IDLE = 3'd3,
        VIO_RCD          = 3'd4,
        VIO_RC           = 3'd5,
        VIO_RP           = 3'd6,
        VIO_MRD          = 3'd7
    } vio_e;

    // Per-bank strobes produced by the command checker.
    typedef struct packed {
        logic act;
        logic rdwr;
        logic ap;
        logic pre;
        logic bst;
        logic refr;
    } bank_op_t;

    // Per-bank status returned to the checker.
    typedef struct packed {
        logic open;
        logic rcd_ok;
        logic rc_ok;
        logic rp_ok;
    } bank_stat_t;

    // Beats of a burst; 0 means full page (no auto precharge).
    function automatic logic [3:0] burst_beats(logic [2:0] code);
        case (code)
            3'd0:    burst_beats = 4'd1;
            3'd1:    burst_beats = 4'd2;
            3'd2:    burst_beats = 4'd4;
            3'd3:    burst_beats = 4'd8;
            default: burst_beats = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdt_timer.sv
module sdt_timer #(
    parameter int LIMIT = 3,
    parameter int CW    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic zero_o
);
    localparam logic [CW-1:0] LOADV = (LIMIT > 1) ? CW'(LIMIT - 1) : '0;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= LOADV;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdt_bank.sv
module sdt_bank
    import sdt_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RC  = 8,
    parameter int T_RP  = 3,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  bank_op_t         op_i,
    input  logic [3:0]       beats_i,
    input  logic [ROW_W-1:0] row_i,
    output bank_stat_t       stat_o,
    output logic [ROW_W-1:0] row_o
);
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             ap_pend_q;
    logic [3:0]       ap_cnt_q;
    logic             close_req;
    logic             close_eff;
    logic             rcd_zero, rc_zero, rp_zero;

    // Precharge request: explicit, single-beat auto, or end of a pending burst.
    always_comb begin
        close_req = op_i.pre
                  | (op_i.rdwr & op_i.ap & (beats_i == 4'd1))
                  | (ap_pend_q & (ap_cnt_q == 4'd1) & ~op_i.rdwr & ~op_i.bst);
        close_eff = close_req & open_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (op_i.act) begin
            open_q <= 1'b1;
            row_q  <= row_i;
        end else if (close_eff) begin
            open_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_pend_q <= 1'b0;
            ap_cnt_q  <= '0;
        end else if (op_i.rdwr) begin
            ap_pend_q <= op_i.ap & (beats_i > 4'd1);
            ap_cnt_q  <= beats_i - 4'd1;
        end else if (op_i.bst | op_i.pre) begin
            ap_pend_q <= 1'b0;
        end else if (ap_pend_q) begin
            ap_cnt_q <= ap_cnt_q - 4'd1;
            if (ap_cnt_q == 4'd1)
                ap_pend_q <= 1'b0;
        end
    end

    sdt_timer #(.LIMIT(T_RCD), .CW(CW)) u_rcd (
        .clk(clk), .rst(rst), .load_i(op_i.act), .zero_o(rcd_zero));

    sdt_timer #(.LIMIT(T_RC), .CW(CW)) u_rc (
        .clk(clk), .rst(rst), .load_i(op_i.act | op_i.refr), .zero_o(rc_zero));

    sdt_timer #(.LIMIT(T_RP), .CW(CW)) u_rp (
        .clk(clk), .rst(rst), .load_i(close_eff), .zero_o(rp_zero));

    assign stat_o = '{open: open_q, rcd_ok: rcd_zero, rc_ok: rc_zero, rp_ok: rp_zero};
    assign row_o  = row_q;

    AST_ACT_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        op_i.act |-> (!open_q && rc_zero && rp_zero)); // R2
    AST_ACT_LOADS_ROW: assert property (@(posedge clk) disable iff (rst)
        op_i.act |=> (open_q && row_q == $past(row_i))); // R2
    AST_RDWR_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        op_i.rdwr |-> (open_q && rcd_zero)); // R3
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (op_i.pre && !op_i.act) |=> !open_q); // R5

endmodule

// File: rtl/sdt_cmd_check.sv
module sdt_cmd_check
    import sdt_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int BANK_W = 2
) (
    input  cmd_e                         cmd_i,
    input  logic [BANK_W-1:0]            bank_i,
    input  logic                         a10_i,
    input  logic [3:0]                   beats_i,
    input  bank_stat_t [NBANK-1:0]       stat_i,
    input  logic                         mrd_busy_i,
    input  logic [BANK_W-1:0]            last_bank_i,
    output bank_op_t [NBANK-1:0]         op_o,
    output logic                         lmr_o,
    output vio_e                         code_o
);
    bank_stat_t sel;
    logic       any_open;
    logic       any_rp;
    logic       legal;

    always_comb begin
        any_open = 1'b0;
        any_rp   = 1'b0;
        for (int b = 0; b < NBANK; b++) begin
            any_open = any_open | stat_i[b].open;
            any_rp   = any_rp | ~stat_i[b].rp_ok;
        end
        sel = stat_i[bank_i];

        code_o = VIO_NONE;
        if (cmd_i != CMD_NOP) begin
            if (mrd_busy_i) begin
                code_o = VIO_MRD;
            end else begin
                case (cmd_i)
                    CMD_ACT: begin
                        if (sel.open)         code_o = VIO_BANK_OPEN;
                        else if (!sel.rc_ok)  code_o = VIO_RC;
                        else if (!sel.rp_ok)  code_o = VIO_RP;
                    end
                    CMD_RD, CMD_WR: begin
                        if (!sel.open)        code_o = VIO_BANK_CLOSED;
                        else if (!sel.rcd_ok) code_o = VIO_RCD;
                    end
                    CMD_REF, CMD_LMR: begin
                        if (any_open)         code_o = VIO_NOT_ALL_IDLE;
                        else if (any_rp)      code_o = VIO_RP;
                    end
                    default: code_o = VIO_NONE;
                endcase
            end
        end
        legal = (code_o == VIO_NONE);

        for (int b = 0; b < NBANK; b++) begin
            op_o[b].act  = legal && cmd_i == CMD_ACT && bank_i == BANK_W'(b);
            op_o[b].rdwr = legal && (cmd_i == CMD_RD || cmd_i == CMD_WR)
                           && bank_i == BANK_W'(b);
            op_o[b].ap   = a10_i && (beats_i != 4'd0);
            op_o[b].pre  = legal && cmd_i == CMD_PRE && (a10_i || bank_i == BANK_W'(b));
            op_o[b].bst  = legal && cmd_i == CMD_BST && last_bank_i == BANK_W'(b);
            op_o[b].refr = legal && cmd_i == CMD_REF;
        end
        lmr_o = legal && cmd_i == CMD_LMR;
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdt_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int ROW_W = 13,
    parameter int T_RCD = 3,
    parameter int T_RC  = 8,
    parameter int T_RP  = 3,
    parameter int T_MRD = 2,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               cmd_i,
    input  logic [BANK_W-1:0]        bank_i,
    input  logic                     a10_i,
    input  logic [ROW_W-1:0]         addr_i,
    input  logic [2:0]               bl_code_i,
    output logic [NBANK-1:0]         bank_open_o,
    output logic [NBANK-1:0]         bank_ready_o,
    output logic [NBANK*ROW_W-1:0]   open_row_o,
    output logic                     viol_o,
    output logic [2:0]               viol_code_o,
    output logic                     viol_sticky_o
);
    localparam int TM1  = (T_RC > T_RCD) ? T_RC : T_RCD;
    localparam int TM2  = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
    localparam int CW   = $clog2(TMAX + 1);

    cmd_e                   cmd;
    logic [3:0]             beats;
    bank_op_t   [NBANK-1:0] op_v;
    bank_stat_t [NBANK-1:0] stat_v;
    logic [NBANK-1:0]       rdwr_v;
    logic [NBANK-1:0]       act_v;
    logic                   lmr;
    logic                   mrd_zero;
    logic                   mrd_busy;
    vio_e                   code;
    logic [BANK_W-1:0]      last_bank_q;
    logic                   viol_q;
    logic [2:0]             code_q;
    logic                   sticky_q;

    assign cmd      = cmd_e'(cmd_i);
    assign beats    = burst_beats(bl_code_i);
    assign mrd_busy = ~mrd_zero;

    sdt_cmd_check #(.NBANK(NBANK), .BANK_W(BANK_W)) u_chk (
        .cmd_i       (cmd),
        .bank_i      (bank_i),
        .a10_i       (a10_i),
        .beats_i     (beats),
        .stat_i      (stat_v),
        .mrd_busy_i  (mrd_busy),
        .last_bank_i (last_bank_q),
        .op_o        (op_v),
        .lmr_o       (lmr),
        .code_o      (code)
    );

    sdt_timer #(.LIMIT(T_MRD), .CW(CW)) u_mrd (
        .clk(clk), .rst(rst), .load_i(lmr), .zero_o(mrd_zero));

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [ROW_W-1:0] row_b;

        sdt_bank #(
            .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP), .CW(CW)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .op_i    (op_v[b]),
            .beats_i (beats),
            .row_i   (addr_i),
            .stat_o  (stat_v[b]),
            .row_o   (row_b)
        );

        assign open_row_o[b*ROW_W +: ROW_W] = row_b;
        assign bank_open_o[b]  = stat_v[b].open;
        assign rdwr_v[b]       = op_v[b].rdwr;
        assign act_v[b]        = op_v[b].act;
        assign bank_ready_o[b] = ~mrd_busy &
            (stat_v[b].open ? stat_v[b].rcd_ok : (stat_v[b].rc_ok & stat_v[b].rp_ok));
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_bank_q <= '0;
        else if (|rdwr_v)
            last_bank_q <= bank_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q   <= 1'b0;
            code_q   <= '0;
            sticky_q <= 1'b0;
        end else begin
            viol_q   <= (code != VIO_NONE);
            code_q   <= code;
            sticky_q <= sticky_q | (code != VIO_NONE);
        end
    end

    assign viol_o        = viol_q;
    assign viol_code_o   = code_q;
    assign viol_sticky_o = sticky_q;

    AST_ONE_ACT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_v)); // R2
    AST_MRD_GUARD: assert property (@(posedge clk) disable iff (rst)
        (mrd_busy && cmd != CMD_NOP) |=> (viol_o && viol_code_o == 3'd7)); // R9
    AST_VIOL_CODE_SET: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_code_o != 3'd0 && viol_sticky_o)); // R11
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        viol_sticky_o |=> viol_sticky_o); // R11

endmodule

// File: tb/sim_sdram_bank_tracker.sv
module sim_sdram_bank_tracker;
    import sdt_pkg::*;

    localparam int NBANK = 4;
    localparam int ROW_W = 13;
    localparam int BANK_W = 2;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [2:0]             cmd_i = 3'd0;
    logic [BANK_W-1:0]      bank_i = '0;
    logic                   a10_i = 1'b0;
    logic [ROW_W-1:0]       addr_i = '0;
    logic [2:0]             bl_code_i = 3'd0;
    logic [NBANK-1:0]       bank_open_o;
    logic [NBANK-1:0]       bank_ready_o;
    logic [NBANK*ROW_W-1:0] open_row_o;
    logic                   viol_o;
    logic [2:0]             viol_code_o;
    logic                   viol_sticky_o;

    int nvec  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    sdram_bank_tracker #(.NBANK(NBANK), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst(rst), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
        .addr_i(addr_i), .bl_code_i(bl_code_i), .bank_open_o(bank_open_o),
        .bank_ready_o(bank_ready_o), .open_row_o(open_row_o), .viol_o(viol_o),
        .viol_code_o(viol_code_o), .viol_sticky_o(viol_sticky_o));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one command at a falling edge; return at the next falling edge.
    task automatic step(cmd_e c, int bk, bit a10, int row, int bl);
        cmd_i     = c;
        bank_i    = BANK_W'(bk);
        a10_i     = a10;
        addr_i    = ROW_W'(row);
        bl_code_i = 3'(bl);
        @(negedge clk);
        cmd_i = CMD_NOP;
        a10_i = 1'b0;
    endtask

    task automatic nops(int n);
        repeat (n) step(CMD_NOP, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        nops(2);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] row_of(int b);
        return 32'(open_row_o[b*ROW_W +: ROW_W]);
    endfunction

    task automatic t_reset();
        do_reset();
        chk("R1 open after reset", 32'(bank_open_o), 32'h0);
        chk("R1 ready after reset", 32'(bank_ready_o), 32'hf);
        chk("R1 viol after reset", 32'(viol_o), 32'h0);
        chk("R1 code after reset", 32'(viol_code_o), 32'h0);
        chk("R1 sticky after reset", 32'(viol_sticky_o), 32'h0);
    endtask

    task automatic t_act();
        do_reset();
        step(CMD_ACT, 1, 0, 'h123, 0);
        chk("R2 bank1 opened", 32'(bank_open_o), 32'h2);
        chk("R2 bank1 row", row_of(1), 32'h123);
        chk("R2 legal act no viol", 32'(viol_o), 32'h0);
        step(CMD_ACT, 1, 0, 'h055, 0);
        chk("R2 act on open bank code", 32'(viol_code_o), 32'h1);
        chk("R11 state error bit2 clear", 32'(viol_code_o[2]), 32'h0);
        chk("R12 row kept after flagged act", row_of(1), 32'h123);
        nops(1);
        chk("R11 viol lasts one cycle", 32'(viol_o), 32'h0);
        chk("R11 sticky holds", 32'(viol_sticky_o), 32'h1);
    endtask

    task automatic t_rcd();
        do_reset();
        step(CMD_ACT, 0, 0, 'h10, 0);
        chk("R13 not ready inside rcd", 32'(bank_ready_o[0]), 32'h0);
        step(CMD_RD, 0, 0, 0, 0);
        chk("R3 read before rcd code", 32'(viol_code_o), 32'h4);
        chk("R11 timing error bit2 set", 32'(viol_code_o[2]), 32'h1);
        nops(1);
        chk("R13 ready once rcd elapsed", 32'(bank_ready_o[0]), 32'h1);
        step(CMD_RD, 0, 0, 0, 0);
        chk("R3 read at rcd legal", 32'(viol_o), 32'h0);
        step(CMD_WR, 2, 0, 0, 0);
        chk("R3 write to idle bank code", 32'(viol_code_o), 32'h2);
    endtask

    task automatic t_rc();
        do_reset();
        step(CMD_ACT, 0, 0, 'h1, 0);
        nops(2);
        step(CMD_PRE, 0, 0, 0, 0);
        nops(2);
        step(CMD_ACT, 0, 0, 'h2, 0);
        chk("R4 act inside rc code", 32'(viol_code_o), 32'h5);
        chk("R12 flagged act leaves idle", 32'(bank_open_o[0]), 32'h0);
        nops(1);
        step(CMD_ACT, 0, 0, 'h2, 0);
        chk("R4 act at rc legal", 32'(viol_o), 32'h0);
        chk("R4 act at rc opens", 32'(bank_open_o[0]), 32'h1);
    endtask

    task automatic t_pre();
        do_reset();
        step(CMD_ACT, 0, 0, 'h20, 0);
        step(CMD_ACT, 1, 0, 'h21, 0);
        nops(6);
        step(CMD_PRE, 0, 0, 0, 0);
        chk("R5 single precharge closes bank0 only", 32'(bank_open_o), 32'h2);
        chk("R13 not ready inside rp", 32'(bank_ready_o[0]), 32'h0);
        step(CMD_ACT, 0, 0, 'h22, 0);
        chk("R5 act inside rp code", 32'(viol_code_o), 32'h6);
        nops(1);
        chk("R13 ready after rp", 32'(bank_ready_o[0]), 32'h1);
        step(CMD_ACT, 0, 0, 'h22, 0);
        chk("R5 act at rp legal", 32'(viol_o), 32'h0);
        chk("R5 both banks open", 32'(bank_open_o), 32'h3);
    endtask

    task automatic t_preall();
        do_reset();
        step(CMD_ACT, 0, 0, 'h3, 0);
        step(CMD_ACT, 2, 0, 'h4, 0);
        step(CMD_ACT, 3, 0, 'h5, 0);
        chk("R6 three banks open", 32'(bank_open_o), 32'hd);
        step(CMD_PRE, 1, 1, 0, 0);
        chk("R6 precharge all closes every bank", 32'(bank_open_o), 32'h0);
        chk("R6 precharge all no viol", 32'(viol_o), 32'h0);
    endtask

    task automatic t_autopre();
        do_reset();
        step(CMD_ACT, 0, 0, 'h30, 0);
        step(CMD_ACT, 1, 0, 'h31, 0);
        nops(6);
        step(CMD_RD, 0, 1, 0, 2);
        chk("R7 bank0 open at beat0", 32'(bank_open_o[0]), 32'h1);
        step(CMD_WR, 1, 1, 0, 0);
        chk("R7 single beat closes at once", 32'(bank_open_o), 32'h1);
        nops(1);
        chk("R7 open through beat2", 32'(bank_open_o[0]), 32'h1);
        nops(1);
        chk("R7 closed after beat3", 32'(bank_open_o[0]), 32'h0);
        step(CMD_ACT, 0, 0, 'h32, 0);
        chk("R7 rp counted from final beat", 32'(viol_code_o), 32'h6);
        nops(1);
        step(CMD_ACT, 0, 0, 'h32, 0);
        chk("R7 act at final beat plus rp legal", 32'(viol_o), 32'h0);
    endtask

    task automatic t_fullpage_bst();
        do_reset();
        step(CMD_ACT, 2, 0, 'h40, 0);
        nops(2);
        step(CMD_RD, 2, 1, 0, 7);
        nops(10);
        chk("R7 full page keeps row open", 32'(bank_open_o[2]), 32'h1);
        step(CMD_ACT, 3, 0, 'h41, 0);
        nops(2);
        step(CMD_WR, 3, 1, 0, 3);
        step(CMD_BST, 0, 0, 0, 0);
        chk("R10 burst terminate not flagged", 32'(viol_o), 32'h0);
        nops(10);
        chk("R10 terminate cancels auto precharge", 32'(bank_open_o[3]), 32'h1);
        chk("R10 rows left open", 32'(bank_open_o), 32'hc);
    endtask

    task automatic t_ref_lmr();
        do_reset();
        step(CMD_REF, 0, 0, 0, 0);
        chk("R8 refresh when idle legal", 32'(viol_o), 32'h0);
        step(CMD_ACT, 0, 0, 'h50, 0);
        chk("R4 act right after refresh code", 32'(viol_code_o), 32'h5);
        nops(6);
        step(CMD_ACT, 0, 0, 'h50, 0);
        chk("R4 act rc after refresh legal", 32'(viol_o), 32'h0);
        step(CMD_REF, 0, 0, 0, 0);
        chk("R8 refresh with open bank code", 32'(viol_code_o), 32'h3);
        step(CMD_PRE, 0, 0, 0, 0);
        step(CMD_REF, 0, 0, 0, 0);
        chk("R8 refresh inside rp code", 32'(viol_code_o), 32'h6);
        nops(1);
        step(CMD_LMR, 0, 0, 0, 0);
        chk("R8 load mode when idle legal", 32'(viol_o), 32'h0);
        step(CMD_ACT, 1, 0, 'h51, 0);
        chk("R9 command inside mrd code", 32'(viol_code_o), 32'h7);
        chk("R9 flagged act ignored", 32'(bank_open_o[1]), 32'h0);
        step(CMD_PRE, 0, 1, 0, 0);
        chk("R9 command at mrd legal", 32'(viol_o), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_act();
        t_rcd();
        t_rc();
        t_pre();
        t_preall();
        t_autopre();
        t_fullpage_bst();
        t_ref_lmr();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule